// File: doc/BRIEF.md
# SATA Host Controller Global Register Block

This block sits at the front of a multi-port SATA host controller register space. A 32-bit memory-mapped slave reaches it. It splits each word-aligned address into one of three regions. The low window holds the controller-wide registers. Equal-sized windows, one per port, are forwarded to the port register blocks. All other addresses fall into a dead region.

The block holds the controller-wide registers itself: capabilities, global control, interrupt status, the implemented-port bitmap and the version word. Each port delivers a one-bit summary of its unmasked interrupt state. The block latches these summaries into the interrupt status register and drives one level interrupt towards the host. Software can request a controller reset through the global control register. The block turns that request into a single-cycle pulse, which clears its own state and is also sent to every port block.

Reads are combinational. `bus_rdata` shows the addressed word in the same cycle that `bus_en` is high, and it is zero while `bus_en` is low. Writes take effect at the rising clock edge where `bus_en` and `bus_we` are both high.

Top module: `hba_glob_regs`

## Requirements
- R1: Addresses 0x000 to 0x028 form the global window, and word index = addr[5:2]. Indices 5 to 10 are placeholders that read as zero and ignore writes.
- R2: Word 0 reads `CAP_FLAGS` with bit 31 forced to 1 (64-bit addressing) and bits [4:0] = NPORTS-1. Word 3 reads a bitmap with the low NPORTS bits set. Word 4 reads `VERSION`. Writes to all three are ignored.
- R3: A write to word 1 with bit 0 = 0 stores bit 1 as the interrupt enable and discards every other bit. Word 1 reads bit 31 = 1 (controller mode always on), bit 1 = the stored enable, and all other bits = 0.
- R4: A write to word 1 with bit 0 = 1 drives `ctrl_rst` high for exactly the one cycle after the write edge. It also returns the interrupt enable and the interrupt status to zero, and `irq` stays low while `ctrl_rst` is high.
- R5: Interrupt status bit n (word 2) becomes 1 at any clock edge where `port_irq_sum[n]` is 1. It keeps that value after the summary drops.
- R6: A write to word 2 clears each status bit whose data bit is 1 and leaves the others untouched. A port summary that is high at the same edge keeps its bit set.
- R7: `irq` is high exactly when the interrupt status is nonzero and the stored enable is 1. It follows from register state, so it changes in the cycle after the write or edge that caused the change.
- R8: An address in [0x100, 0x100 + NPORTS*0x80) selects port (addr-0x100)>>7. `port_sel` is one-hot on that port, `port_off` = addr[6:0], `bus_rdata` = that port's slice of `port_rdata`, and `port_we` = `bus_we`. `port_sel` is never more than one-hot.
- R9: An address in neither window reads zero and drives `port_sel` to zero and `port_we` low. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| port_rdata | input | NPORTS*32 | Read data from each port block, port n at [n*32 +: 32] |
| port_irq_sum | input | NPORTS | Per-port unmasked interrupt summary |
| port_sel | output | NPORTS | One-hot port window select |
| port_off | output | 7 | Offset inside the port window |
| port_we | output | 1 | Write strobe to the selected port |
| ctrl_rst | output | 1 | One-cycle controller reset pulse |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with NPORTS = 6 and ADDR_W = 12, so the port windows end at 0x400. This puts both edges of the port region and the far end of the address space within reach. Six ports also make bits [4:0] of the capabilities word and the width of the implemented-port bitmap differ from the defaults. Because port 3 and port 5 sit away from the low bits, the one-hot select and the status bit mapping get checked at positions that a two-port build would never reach.

// File: rtl/hba_pkg.sv
// Shared constants for the global register block.
// Assumes word-aligned byte addresses and a 32-bit data path.
package hba_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_GLOB = 2'd1,
        RGN_PORT = 2'd2
    } rgn_e;

    localparam int GLOB_LIMIT   = 'h2C;   // first byte past the global window
    localparam int PORT_BASE    = 'h100;  // first port window
    localparam int PORT_SHIFT   = 7;      // log2 of the port window stride
    localparam int OFF_W        = 7;

    localparam logic [3:0] WIDX_CAP  = 4'd0;
    localparam logic [3:0] WIDX_CTRL = 4'd1;
    localparam logic [3:0] WIDX_STAT = 4'd2;
    localparam logic [3:0] WIDX_IMPL = 4'd3;
    localparam logic [3:0] WIDX_VER  = 4'd4;

    localparam int CTRL_RST_BIT = 0;
    localparam int CTRL_IE_BIT  = 1;
    localparam int CTRL_AE_BIT  = 31;
    localparam int CAP_WIDE_BIT = 31;

endpackage

// File: rtl/hba_addr_dec.sv
// Address decoder. Classifies a byte address into the global window,
// one of NPORTS port windows, or nothing. Purely combinational.
// Assumes ADDR_W is wide enough to hold PORT_BASE + NPORTS*stride - 1.
module hba_addr_dec
    import hba_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 12
) (
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output rgn_e              rgn,
    output logic [3:0]        glob_idx,
    output logic [NPORTS-1:0] sel,
    output logic [OFF_W-1:0]  off
);
    localparam int PIDX_W = ADDR_W - PORT_SHIFT;
    localparam logic [ADDR_W:0] GLOB_END = (ADDR_W+1)'(GLOB_LIMIT);
    localparam logic [ADDR_W:0] PBASE    = (ADDR_W+1)'(PORT_BASE);
    localparam logic [ADDR_W:0] PEND     = (ADDR_W+1)'(PORT_BASE + NPORTS * (1 << PORT_SHIFT));

    logic [ADDR_W:0]   addr_x;
    logic [ADDR_W-1:0] rel;
    logic [PIDX_W-1:0] pidx;

    // region classification from the address alone
    always_comb begin
        addr_x = {1'b0, bus_addr};
        if (addr_x < GLOB_END)
            rgn = RGN_GLOB;
        else if (addr_x >= PBASE && addr_x < PEND)
            rgn = RGN_PORT;
        else
            rgn = RGN_NONE;
    end

    assign rel      = bus_addr - ADDR_W'(PORT_BASE);
    assign pidx     = rel[ADDR_W-1:PORT_SHIFT];
    assign glob_idx = bus_addr[5:2];
    assign off      = bus_addr[OFF_W-1:0];

    // one select line per port window
    for (genvar g = 0; g < NPORTS; g++) begin : g_sel
        assign sel[g] = bus_en && (rgn == RGN_PORT) && (pidx == PIDX_W'(g));
    end

endmodule

// File: rtl/hba_irq_agg.sv
// Interrupt status register and host interrupt level.
// Port summaries set status bits, software writes clear them (a set at
// the same edge wins), and a soft reset clears everything.
module hba_irq_agg #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [NPORTS-1:0] port_irq_sum,
    input  logic              clr_en,
    input  logic [NPORTS-1:0] clr_mask,
    input  logic              ie,
    output logic [NPORTS-1:0] stat,
    output logic              irq
);
    logic [NPORTS-1:0] stat_q;
    logic [NPORTS-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_mask : '0;

    // sticky status: clear-on-one, set-by-port, set wins
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_eff) | port_irq_sum;
    end

    // level output derived from held state only
    assign irq  = ie && (|stat_q);
    assign stat = stat_q;

endmodule

// File: rtl/hba_glob_rf.sv
// Controller-wide register file: capabilities, control, implemented
// ports and version, plus the read mux for the global window.
// Assumes glob_idx is only meaningful while the global window is hit.
module hba_glob_rf
    import hba_pkg::*;
#(
    parameter int          NPORTS    = 4,
    parameter logic [31:0] CAP_FLAGS = 32'h4000_0000,
    parameter logic [31:0] VERSION   = 32'h0001_0300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        glob_idx,
    input  logic [31:0]       wdata,
    input  logic [NPORTS-1:0] stat,
    output logic [31:0]       rd_val,
    output logic              ie,
    output logic              rst_req,
    output logic              ctrl_rst
);
    localparam logic [31:0] CAP_VAL  = CAP_FLAGS | (32'h1 << CAP_WIDE_BIT) | 32'(NPORTS - 1);
    localparam logic [NPORTS-1:0] IMPL_BITS = '1;

    logic        ie_q;
    logic        pulse_q;
    logic        ctrl_wr;
    logic [31:0] impl_val;
    logic [31:0] stat_val;

    assign ctrl_wr = wr_en && (glob_idx == WIDX_CTRL);
    assign rst_req = ctrl_wr && wdata[CTRL_RST_BIT];

    // interrupt enable: stored on plain control writes, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n || rst_req)
            ie_q <= 1'b0;
        else if (ctrl_wr)
            ie_q <= wdata[CTRL_IE_BIT];
    end

    // one-cycle reset pulse following a reset request
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= rst_req;
    end

    // zero-extend the narrow bitmaps to the bus width
    always_comb begin
        impl_val = '0;
        impl_val[NPORTS-1:0] = IMPL_BITS;
        stat_val = '0;
        stat_val[NPORTS-1:0] = stat;
    end

    // global window read mux
    always_comb begin
        case (glob_idx)
            WIDX_CAP:  rd_val = CAP_VAL;
            WIDX_CTRL: rd_val = (32'h1 << CTRL_AE_BIT) | (32'(ie_q) << CTRL_IE_BIT);
            WIDX_STAT: rd_val = stat_val;
            WIDX_IMPL: rd_val = impl_val;
            WIDX_VER:  rd_val = VERSION;
            default:   rd_val = '0;
        endcase
    end

    assign ie       = ie_q;
    assign ctrl_rst = pulse_q;

endmodule

// File: rtl/hba_glob_regs.sv
// Top of the global register block. Decodes the slave bus, routes port
// window accesses to the port blocks, holds the global registers and
// produces the host interrupt and the controller reset pulse.
// Assumes single-beat 32-bit accesses, no byte enables.
module hba_glob_regs
    import hba_pkg::*;
#(
    parameter int          NPORTS    = 4,
    parameter int          ADDR_W    = 12,
    parameter logic [31:0] CAP_FLAGS = 32'h4000_0000,
    parameter logic [31:0] VERSION   = 32'h0001_0300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NPORTS*32-1:0] port_rdata,
    input  logic [NPORTS-1:0]    port_irq_sum,
    output logic [NPORTS-1:0]    port_sel,
    output logic [OFF_W-1:0]     port_off,
    output logic                 port_we,
    output logic                 ctrl_rst,
    output logic                 irq
);
    rgn_e              rgn;
    logic [3:0]        glob_idx;
    logic [31:0]       glob_rd;
    logic [31:0]       port_rd;
    logic              glob_wr;
    logic              ie;
    logic              rst_req;
    logic [NPORTS-1:0] stat;

    hba_addr_dec #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_dec (
        .bus_en   (bus_en),
        .bus_addr (bus_addr),
        .rgn      (rgn),
        .glob_idx (glob_idx),
        .sel      (port_sel),
        .off      (port_off)
    );

    assign glob_wr = bus_en && bus_we && (rgn == RGN_GLOB);

    hba_glob_rf #(.NPORTS(NPORTS), .CAP_FLAGS(CAP_FLAGS), .VERSION(VERSION)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (glob_wr),
        .glob_idx (glob_idx),
        .wdata    (bus_wdata),
        .stat     (stat),
        .rd_val   (glob_rd),
        .ie       (ie),
        .rst_req  (rst_req),
        .ctrl_rst (ctrl_rst)
    );

    hba_irq_agg #(.NPORTS(NPORTS)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (rst_req || ctrl_rst),
        .port_irq_sum (port_irq_sum),
        .clr_en       (glob_wr && (glob_idx == WIDX_STAT)),
        .clr_mask     (bus_wdata[NPORTS-1:0]),
        .ie           (ie),
        .stat         (stat),
        .irq          (irq)
    );

    // pick the selected port's read word
    always_comb begin
        port_rd = '0;
        for (int g = 0; g < NPORTS; g++)
            if (port_sel[g])
                port_rd = port_rdata[g*32 +: 32];
    end

    // final read mux by region
    always_comb begin
        if (!bus_en)
            bus_rdata = '0;
        else if (rgn == RGN_GLOB)
            bus_rdata = glob_rd;
        else if (rgn == RGN_PORT)
            bus_rdata = port_rd;
        else
            bus_rdata = '0;
    end

    assign port_we = bus_en && bus_we && (rgn == RGN_PORT);

endmodule

// File: rtl/hba_glob_chk.sv
// Property checker for hba_glob_regs, observing its ports only.
module hba_glob_chk #(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPORTS-1:0] port_sel,
    input logic              ctrl_rst,
    input logic              irq
);
    logic ctrl_wr;
    logic in_gap;

    assign ctrl_wr = bus_en && bus_we && (bus_addr == ADDR_W'('h004));
    assign in_gap  = (bus_addr >= ADDR_W'('h02C)) && (bus_addr < ADDR_W'('h100));

    AST_IE_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !bus_wdata[1] |=> !irq); // R7

    AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rst) |-> $past(ctrl_wr && bus_wdata[0])); // R4

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst |=> (!ctrl_rst || $past(ctrl_wr && bus_wdata[0]))); // R4

    AST_RST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst |-> !irq); // R4

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel)); // R8

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && in_gap |-> (bus_rdata == 32'h0) && (port_sel == '0)); // R9

    AST_CAP_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && !bus_we && (bus_addr == '0) |-> bus_rdata[31]); // R2

endmodule

bind hba_glob_regs hba_glob_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_sel  (port_sel),
    .ctrl_rst  (ctrl_rst),
    .irq       (irq)
);

// File: tb/test_hba_glob_regs.sv
// Self-checking bench for hba_glob_regs: a read table, then directed tests.
module test_hba_glob_regs;
    localparam int NP = 6;
    localparam int AW = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_en = 1'b0;
    logic           bus_we = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NP*32-1:0] port_rdata;
    logic [NP-1:0]  port_irq_sum = '0;
    logic [NP-1:0]  port_sel;
    logic [6:0]     port_off;
    logic           port_we;
    logic           ctrl_rst;
    logic           irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    for (genvar p = 0; p < NP; p++) begin : g_prd
        assign port_rdata[p*32 +: 32] = 32'hD0D0_0000 + p;
    end

    hba_glob_regs #(.NPORTS(NP), .ADDR_W(AW), .CAP_FLAGS(32'h4000_0000),
                    .VERSION(32'h0001_0300)) i_hba_glob_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_rdata(port_rdata), .port_irq_sum(port_irq_sum),
        .port_sel(port_sel), .port_off(port_off), .port_we(port_we),
        .ctrl_rst(ctrl_rst), .irq(irq)
    );

    // {req[3:0], exp_sel[5:0], addr[11:0], exp_rdata[31:0]}
    localparam int NV = 15;
    localparam logic [53:0] TBL [NV] = '{
        {4'd2, 6'h00, 12'h000, 32'hC000_0005},
        {4'd3, 6'h00, 12'h004, 32'h8000_0000},
        {4'd5, 6'h00, 12'h008, 32'h0000_0000},
        {4'd2, 6'h00, 12'h00C, 32'h0000_003F},
        {4'd2, 6'h00, 12'h010, 32'h0001_0300},
        {4'd1, 6'h00, 12'h014, 32'h0000_0000},
        {4'd1, 6'h00, 12'h028, 32'h0000_0000},
        {4'd9, 6'h00, 12'h02C, 32'h0000_0000},
        {4'd9, 6'h00, 12'h0FC, 32'h0000_0000},
        {4'd8, 6'h01, 12'h100, 32'hD0D0_0000},
        {4'd8, 6'h01, 12'h17C, 32'hD0D0_0000},
        {4'd8, 6'h02, 12'h180, 32'hD0D0_0001},
        {4'd8, 6'h20, 12'h3FC, 32'hD0D0_0005},
        {4'd9, 6'h00, 12'h400, 32'h0000_0000},
        {4'd9, 6'h00, 12'hFFC, 32'h0000_0000}
    };

    function automatic string rname(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            5: return "R5";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // read: drive at negedge, sample 1 ns later (combinational path)
    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // write: drive at negedge, captured at the next posedge, returns at negedge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R4 reset state
        chk(!irq && !ctrl_rst, "R4", "irq/ctrl_rst after reset", {30'd0, irq, ctrl_rst}, 32'h0);

        // table walk: R1 R2 R3 R5 R8 R9 reads
        for (int i = 0; i < NV; i++) begin
            rd(TBL[i][43:32], d);
            chk(d == TBL[i][31:0], rname(int'(TBL[i][53:50])), "table rdata", d, TBL[i][31:0]);
            chk(port_sel == TBL[i][49:44], rname(int'(TBL[i][53:50])), "table port_sel",
                32'(port_sel), 32'(TBL[i][49:44]));
        end

        // R8 port write routing to port 3, offset 0x04
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h284; bus_wdata = 32'h55;
        #1;
        chk(port_we && port_sel == 6'h08 && port_off == 7'h04, "R8", "port write route",
            {port_we, 15'd0, 2'd0, port_sel, 1'b0, port_off}, {1'b1, 15'd0, 2'd0, 6'h08, 1'b0, 7'h04});
        // R9 write into dead region: no select, no strobe
        @(negedge clk);
        bus_addr = 12'h040; bus_wdata = 32'hFFFF_FFFF;
        #1;
        chk(!port_we && port_sel == '0, "R9", "dead write strobes", {31'd0, port_we}, 32'h0);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        rd(12'h004, d);
        chk(d == 32'h8000_0000, "R9", "ctrl after dead write", d, 32'h8000_0000);

        // R2 read-only words ignore writes; R1 placeholder ignores writes
        wr(12'h000, 32'h0);
        wr(12'h00C, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h000, d); chk(d == 32'hC000_0005, "R2", "cap after write", d, 32'hC000_0005);
        rd(12'h00C, d); chk(d == 32'h0000_003F, "R2", "impl after write", d, 32'h3F);
        rd(12'h010, d); chk(d == 32'h0001_0300, "R2", "version after write", d, 32'h0001_0300);
        rd(12'h018, d); chk(d == 32'h0, "R1", "placeholder after write", d, 32'h0);

        // R5 port summary sets status, sticky after drop
        @(negedge clk); bus_en = 1'b0;
        port_irq_sum = 6'b001010;
        @(negedge clk);
        port_irq_sum = '0;
        @(negedge clk);
        rd(12'h008, d); chk(d == 32'h0A, "R5", "status sticky", d, 32'h0A);
        chk(!irq, "R7", "irq with enable off", {31'd0, irq}, 32'h0);

        // R3 enable store, other bits discarded
        wr(12'h004, 32'h7FFF_FFFE);
        rd(12'h004, d); chk(d == 32'h8000_0002, "R3", "ctrl with enable", d, 32'h8000_0002);
        chk(irq, "R7", "irq enabled with status", {31'd0, irq}, 32'h1);

        // R6 write-one-to-clear of bit 1 only
        wr(12'h008, 32'h0000_0002);
        rd(12'h008, d); chk(d == 32'h08, "R6", "partial clear", d, 32'h08);

        // R6 set wins over clear at the same edge
        @(negedge clk); bus_en = 1'b0;
        port_irq_sum = 6'b001000;
        wr(12'h008, 32'h0000_0008);
        port_irq_sum = '0;
        rd(12'h008, d); chk(d == 32'h08, "R6", "set beats clear", d, 32'h08);
        wr(12'h008, 32'h0000_0008);
        rd(12'h008, d); chk(d == 32'h0, "R6", "full clear", d, 32'h0);
        chk(!irq, "R7", "irq after status cleared", {31'd0, irq}, 32'h0);

        // R3 plain write with enable clear
        wr(12'h004, 32'hFFFF_FFFC);
        rd(12'h004, d); chk(d == 32'h8000_0000, "R3", "ctrl enable off", d, 32'h8000_0000);

        // R4 reset request: set state first, then request reset
        wr(12'h004, 32'h0000_0002);
        @(negedge clk); bus_en = 1'b0;
        port_irq_sum = 6'b100000;
        @(negedge clk);
        port_irq_sum = '0;
        #1 chk(irq, "R7", "irq before reset", {31'd0, irq}, 32'h1);
        wr(12'h004, 32'h0000_0001);
        #1 chk(ctrl_rst && !irq, "R4", "pulse high, irq low", {30'd0, ctrl_rst, irq}, 32'h2);
        @(negedge clk);
        #1 chk(!ctrl_rst, "R4", "pulse lasts one cycle", {31'd0, ctrl_rst}, 32'h0);
        rd(12'h004, d); chk(d == 32'h8000_0000, "R4", "ctrl after reset", d, 32'h8000_0000);
        rd(12'h008, d); chk(d == 32'h0, "R4", "status after reset", d, 32'h0);

        @(negedge clk); bus_en = 1'b0;
        finish_run();
    end

endmodule